// File: doc/BRIEF.md
# Status Register Write-Protect Gate

This block guards the non-volatile bits of a device status register against writes. A request carrying a new status value arrives on a valid/ready stream. The gate then decides whether the write may proceed. It bases that decision on two things: an active-low guard pin, and a guard-enable bit that is itself stored in the non-volatile part of the status register. A granted write is timed as an internal write lasting a fixed number of cycles. The new non-volatile value becomes visible when that write completes. A blocked write leaves the register untouched and produces a one-cycle reject pulse.

The guard pin only matters once the guard-enable bit is set. A board can therefore tie the pin low and still program the status register freely until software turns the enable bit on. After that, the pin must be high for any status write to take effect, including a write that would clear the enable bit again. The decision is taken once, at the handshake, and is held for the whole write. Volatile status bits are not written by requests. They pass straight from their own input to the register output. Request back-pressure follows standard rules. `req_ready_o` is low while an internal write is running or while the external busy input is high. A transfer takes place on any rising clock edge where `req_valid_i` and `req_ready_o` are both high. The requester keeps `req_valid_i` high and `req_data_i` stable until that edge.

Top module: `sr_wp_gate`

## Requirements
- R1: After reset the non-volatile bits of `sr_o` equal the reset value (all zero by default), `wr_busy_o`, `grant_o` and `reject_o` are low, and `req_ready_o` is high while `ext_busy_i` is low.
- R2: While the guard-enable bit (bit 7 of the register) is 0, every status write is granted whatever the level of `guard_n_i`.
- R3: While the guard-enable bit is 1 and `guard_n_i` is high at the handshake, the write is granted.
- R4: While the guard-enable bit is 1 and `guard_n_i` is low at the handshake, the write is blocked. `reject_o` pulses high for exactly the one cycle after the handshake, and no non-volatile bit of `sr_o` changes.
- R5: A granted write raises `wr_busy_o` for exactly WR_CYCLES (default 6) cycles, starting the cycle after the handshake. The non-volatile bits take the requested value on the edge where `wr_busy_o` falls. A later low level on `guard_n_i` does not cancel or shorten the write.
- R6: `req_ready_o` is low whenever `wr_busy_o` or `ext_busy_i` is high. A request held valid during that time waits and is taken, unchanged, once ready returns.
- R7: The volatile positions of `sr_o` (bits 1 and 0) always equal the same bits of `vol_i`. Request data in those positions and in the unused positions (bits 6 to 4) is ignored, and unused positions read 0. The non-volatile positions are bits 7, 3 and 2.
- R8: Each handshake produces exactly one pulse, on `grant_o` or on `reject_o`, in the following cycle. The two are never high together.
- R9: The guard-enable bit is protected like any other non-volatile bit. Once it is set, a write that would clear it is blocked while `guard_n_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| guard_n_i | input | 1 | Write-guard pin, low requests protection |
| ext_busy_i | input | 1 | Another internal write is running; stalls requests |
| req_valid_i | input | 1 | Status-write request valid |
| req_ready_o | output | 1 | Gate can take a request |
| req_data_i | input | SR_W | Requested new status value |
| vol_i | input | SR_W | Volatile status bits from elsewhere in the device |
| sr_o | output | SR_W | Current status register view |
| wr_busy_o | output | 1 | Granted status write in progress |
| grant_o | output | 1 | One-cycle pulse: the last request was granted |
| reject_o | output | 1 | One-cycle pulse: the last request was blocked |

## Verification
On every cycle the assertions check several properties. Grant and reject are mutually exclusive. A handshake under an active guard always ends in a reject, and one with the enable bit clear always ends in a grant. The non-volatile bits stay still whenever no write is running, and ready stays low during a write. A counter confirms that every busy window lasts exactly WR_CYCLES cycles, so a guard drop mid-write cannot cut it short. Only the bench's scenarios can show that the committed value is the one requested at the handshake. They also show that the enable bit can lock itself in place, and that a request stalled by back-pressure still completes with its original data.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [1:0] {
    VERDICT_IDLE  = 2'd0,
    VERDICT_GRANT = 2'd1,
    VERDICT_BLOCK = 2'd2
  } verdict_e;

  // Protection applies only when the enable bit is set and the pin is low.
  function automatic logic guard_blocks(input logic en_bit, input logic guard_n);
    return en_bit && !guard_n;
  endfunction

endpackage

// File: rtl/srg_protect_eval.sv
module srg_protect_eval #(
  parameter int SR_W   = 8,
  parameter int EN_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic            guard_n_i,
  input  logic [SR_W-1:0] nv_i,
  output logic            allow_o,
  output logic            grant_o,
  output logic            reject_o
);
  import srg_pkg::*;

  verdict_e verdict_q;
  verdict_e verdict_d;

  assign allow_o = !guard_blocks(nv_i[EN_BIT], guard_n_i);

  always_comb begin
    verdict_d = VERDICT_IDLE;
    if (fire_i) verdict_d = allow_o ? VERDICT_GRANT : VERDICT_BLOCK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_q <= VERDICT_IDLE;
    else        verdict_q <= verdict_d;
  end

  assign grant_o  = (verdict_q == VERDICT_GRANT);
  assign reject_o = (verdict_q == VERDICT_BLOCK);

endmodule

// File: rtl/srg_write_timer.sv
module srg_write_timer #(
  parameter int WR_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start_i) cnt_q <= LOAD;
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/srg_nv_store.sv
module srg_nv_store #(
  parameter int              SR_W     = 8,
  parameter logic [SR_W-1:0] NV_MASK  = 8'h8C,
  parameter logic [SR_W-1:0] VOL_MASK = 8'h03,
  parameter logic [SR_W-1:0] SR_RESET = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_i,
  input  logic [SR_W-1:0] cap_data_i,
  input  logic            commit_i,
  input  logic [SR_W-1:0] vol_i,
  output logic [SR_W-1:0] nv_o,
  output logic [SR_W-1:0] sr_o
);
  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    if (NV_MASK[i]) begin : g_nv
      logic pend_q;
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (capture_i) pend_q <= cap_data_i[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cell_q <= SR_RESET[i];
        else if (commit_i) cell_q <= pend_q;
      end
      assign nv_o[i] = cell_q;
      assign sr_o[i] = cell_q;
    end else if (VOL_MASK[i]) begin : g_vol
      assign nv_o[i] = 1'b0;
      assign sr_o[i] = vol_i[i];
    end else begin : g_unused
      assign nv_o[i] = 1'b0;
      assign sr_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/sr_wp_gate.sv
module sr_wp_gate #(
  parameter int              SR_W      = 8,
  parameter int              EN_BIT    = 7,
  parameter logic [SR_W-1:0] NV_MASK   = 8'h8C,
  parameter logic [SR_W-1:0] VOL_MASK  = 8'h03,
  parameter logic [SR_W-1:0] SR_RESET  = 8'h00,
  parameter int              WR_CYCLES = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            guard_n_i,
  input  logic            ext_busy_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [SR_W-1:0] req_data_i,
  input  logic [SR_W-1:0] vol_i,
  output logic [SR_W-1:0] sr_o,
  output logic            wr_busy_o,
  output logic            grant_o,
  output logic            reject_o
);
  logic            fire;
  logic            allow;
  logic            start;
  logic            last;
  logic [SR_W-1:0] nv;

  assign req_ready_o = !wr_busy_o && !ext_busy_i;
  assign fire        = req_valid_i && req_ready_o;
  assign start       = fire && allow;

  srg_protect_eval #(.SR_W(SR_W), .EN_BIT(EN_BIT)) u_eval (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .guard_n_i(guard_n_i),
    .nv_i(nv), .allow_o(allow), .grant_o(grant_o), .reject_o(reject_o)
  );

  srg_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(wr_busy_o), .last_o(last)
  );

  srg_nv_store #(
    .SR_W(SR_W), .NV_MASK(NV_MASK), .VOL_MASK(VOL_MASK), .SR_RESET(SR_RESET)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .capture_i(start), .cap_data_i(req_data_i),
    .commit_i(last), .vol_i(vol_i), .nv_o(nv), .sr_o(sr_o)
  );

endmodule

// File: rtl/sr_wp_gate_chk.sv
module sr_wp_gate_chk #(
  parameter int              SR_W      = 8,
  parameter int              EN_BIT    = 7,
  parameter logic [SR_W-1:0] NV_MASK   = 8'h8C,
  parameter logic [SR_W-1:0] VOL_MASK  = 8'h03,
  parameter int              WR_CYCLES = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            guard_n_i,
  input logic            ext_busy_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [SR_W-1:0] vol_i,
  input logic [SR_W-1:0] sr_o,
  input logic            wr_busy_o,
  input logic            grant_o,
  input logic            reject_o
);
  localparam int CW = $clog2(WR_CYCLES + 2);

  logic          hs;
  logic [CW-1:0] run_q;

  assign hs = req_valid_i && req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (wr_busy_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  p_free_when_en_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !sr_o[EN_BIT]) |=> grant_o);

  p_grant_when_pin_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && guard_n_i) |=> grant_o);

  p_block_when_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && sr_o[EN_BIT] && !guard_n_i) |=> (reject_o && !wr_busy_o));

  p_nv_quiet_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy_o |=> $stable(sr_o & NV_MASK));

  p_busy_not_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_o |-> (run_q < CW'(WR_CYCLES)));

  p_busy_not_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_busy_o && run_q != '0) |-> (run_q == CW'(WR_CYCLES)));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy_o || ext_busy_i) |-> !req_ready_o);

  p_vol_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & VOL_MASK) == (vol_i & VOL_MASK));

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && reject_o));

  p_verdict_needs_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> !(grant_o || reject_o));

endmodule

bind sr_wp_gate sr_wp_gate_chk #(
  .SR_W(SR_W), .EN_BIT(EN_BIT), .NV_MASK(NV_MASK), .VOL_MASK(VOL_MASK),
  .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .guard_n_i(guard_n_i), .ext_busy_i(ext_busy_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .vol_i(vol_i),
  .sr_o(sr_o), .wr_busy_o(wr_busy_o), .grant_o(grant_o), .reject_o(reject_o)
);

// File: tb/sim_sr_wp_gate.sv
module sim_sr_wp_gate;
  localparam int         WC   = 6;
  localparam logic [7:0] NVM  = 8'h8C;
  localparam logic [7:0] VOLM = 8'h03;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       guard_n = 1'b1, ext_busy = 1'b0, req_valid = 1'b0;
  logic [7:0] req_data = 8'h00, vol = 8'h00;
  logic       req_ready, wr_busy, grant, reject;
  logic [7:0] sr;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  sr_wp_gate u0 (
    .clk(clk), .rst_n(rst_n), .guard_n_i(guard_n), .ext_busy_i(ext_busy),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_data_i(req_data),
    .vol_i(vol), .sr_o(sr), .wr_busy_o(wr_busy), .grant_o(grant), .reject_o(reject)
  );

  // behavioural reference
  logic [7:0] m_nv = 8'h00, m_pend = 8'h00;
  int         m_timer = 0;
  logic       m_grant = 1'b0, m_reject = 1'b0;

  always @(posedge clk) begin
    logic mr, mf, ma;
    if (!rst_n) begin
      m_nv = 8'h00; m_pend = 8'h00; m_timer = 0; m_grant = 0; m_reject = 0;
    end else begin
      mr = (m_timer == 0) && !ext_busy;
      mf = req_valid && mr;
      ma = !(m_nv[7] && !guard_n);
      m_grant  = mf && ma;
      m_reject = mf && !ma;
      if (mf && ma) begin
        m_timer = WC;
        m_pend  = req_data & NVM;
      end else if (m_timer > 0) begin
        if (m_timer == 1) m_nv = m_pend;
        m_timer = m_timer - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 ready", req_ready, (m_timer == 0) && !ext_busy);
      chk("R2 grant", grant, m_grant);
      chk("R4 reject", reject, m_reject);
      chk("R5 busy", wr_busy, m_timer > 0);
      chk("R5 sr", sr, (m_nv & NVM) | (vol & VOLM));
      chk("R8 exclusive", grant && reject, 1'b0);
    end
  end

  task automatic wr(input logic [7:0] d, input logic g);
    @(negedge clk); #2;
    req_valid = 1'b1; req_data = d; guard_n = g;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk);
    @(negedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (WC + 2) @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 sr", sr, 8'h00);
    chk("R1 busy", wr_busy, 1'b0);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 pulses", grant | reject, 1'b0);

    wr(8'h0C, 1'b0); settle();            // enable clear, pin low: granted
    chk("R2 pin ignored", sr, 8'h0C);
    wr(8'h84, 1'b0); settle();            // sets the enable bit
    chk("R2 enable set", sr, 8'h84);
    wr(8'h88, 1'b1); settle();
    chk("R3 pin high", sr, 8'h88);
    wr(8'h04, 1'b0); #1;                  // guarded: blocked
    chk("R4 reject pulse", reject, 1'b1);
    settle();
    chk("R4 unchanged", sr, 8'h88);
    chk("R9 enable kept", sr[7], 1'b1);

    wr(8'h8C, 1'b1); #1;                  // drop pin during the write
    chk("R5 busy started", wr_busy, 1'b1);
    guard_n = 1'b0;
    settle();
    chk("R5 committed", sr, 8'h8C);

    ext_busy = 1'b1;
    fork
      wr(8'h84, 1'b1);
      begin
        repeat (4) @(negedge clk);
        #1 chk("R6 stalled", req_ready, 1'b0);
        #2 ext_busy = 1'b0;
      end
    join
    settle();
    chk("R6 taken", sr, 8'h84);

    wr(8'h88, 1'b1);                      // back-to-back: second waits
    wr(8'h8C, 1'b1); settle();
    chk("R6 back to back", sr, 8'h8C);

    vol = 8'h02;
    wr(8'hFF, 1'b1); settle();
    chk("R7 masked", sr, 8'h8E);
    @(negedge clk); #2 vol = 8'hFD;
    @(negedge clk); #1;
    chk("R7 vol pass", sr, 8'h8D);

    wr(8'h08, 1'b1); settle();            // clear enable with pin high
    chk("R9 cleared", sr, 8'h09);
    wr(8'h80, 1'b0); settle();            // pin ignored again
    chk("R2 after clear", sr, 8'h81);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule